// File: doc/BRIEF.md
# Bus-Error Machine-Check Latch

This block sits in a host-bridge controller between the processor bus and memory, and it watches every processor bus transaction. When a transfer ends in error, for example an access to an unmapped address or to an optional board that is not fitted, the block drives its active-low machine-check output to the CPU and keeps it low. The output goes high again only when the CPU's exception entry reads the first instruction word of the machine-check vector over the bus. The vector may sit at either of two bases. The read may be an instruction fetch or a plain data load, and the block treats both the same way.

Each transaction has two parts. The address phase (`abStart`) gives the address and the direction, and the block latches them. The completion (`xferDone`) reports whether the transfer failed. Only one transaction is outstanding at a time. A separate status view records the first failing address and its direction, and flags any further error that arrives while the machine check is still pending. Software clears that status with a write-one-to-clear strobe, and the strobe has no effect on the machine-check line. A global enable gates the output pin but does not stop error capture.

Top module: `mc_latch`

## Requirements
- R1: A completion with `xferErr`=1 makes `mcpN` go low from the next cycle when `mcEnable`=1. In that same cycle `stsValid`=1, `stsAddr` holds the address latched in that transaction's address phase, and `stsWasWrite` is the inverse of the latched `abRead`.
- R2: Once low, `mcpN` stays low across idle cycles and across error-free transactions that do not acknowledge.
- R3: An error-free completed read whose address lies in 0x00000200..0x00000207 drives `mcpN` high from the next cycle.
- R4: An error-free completed read whose address lies in 0xFFF00200..0xFFF00207 also drives `mcpN` high from the next cycle.
- R5: The acknowledging read does not release `mcpN` during its address phase or while it waits for completion. The release happens only at the clock edge that samples its `xferDone`.
- R6: Writes to either vector window never release `mcpN`. Reads outside both windows (such as 0x1FF, 0x208 and 0xFFF00208) never release it either.
- R7: An error completion while the machine check is pending sets `stsOverflow`=1 and keeps `mcpN` low.
- R8: The status is sticky: a later error does not replace `stsAddr` while `stsValid`=1. A `stsClr` pulse clears `stsValid` and `stsOverflow` without changing `mcpN`. If an error completion happens in the same cycle as `stsClr`, that error is recorded.
- R9: A read into a vector window that itself completes with an error counts as an error, not as an acknowledge. `mcpN` stays low and `stsOverflow` is set.
- R10: With `mcEnable`=0, `mcpN` is held high, but errors are still captured in status and the machine check stays pending. Setting `mcEnable`=1 again drives `mcpN` low.
- R11: After reset, `mcpN`=1, `stsValid`=0 and `stsOverflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| abStart | input | 1 | Address-phase strobe; latches `abAddr` and `abRead` |
| abAddr | input | 32 | Transaction address |
| abRead | input | 1 | 1 = read (fetch or load), 0 = write |
| xferDone | input | 1 | Completion strobe of the outstanding transaction |
| xferErr | input | 1 | With `xferDone`, 1 = transfer error |
| mcEnable | input | 1 | Global enable for driving the machine-check output |
| stsClr | input | 1 | Write-one-to-clear pulse for the status flags |
| mcpN | output | 1 | Active-low machine check to the CPU |
| stsValid | output | 1 | An error has been recorded |
| stsOverflow | output | 1 | A further error arrived while the machine check was pending |
| stsAddr | output | 32 | Address of the first recorded error |
| stsWasWrite | output | 1 | The recorded error was a write |

## Verification
The hardest case to reach from the ports is a completion cycle that carries two events at once. One is an error on a read into a vector window, which must count as an error and not as an acknowledge. The other is an error that lands in the same cycle as a status clear. The bench reaches both by driving its transaction task with the window address and the error flag set together, and by letting that task raise `stsClr` in the completion cycle itself. It also samples `mcpN` between the address phase and the completion of an acknowledging read, to show that the release waits for the completion.

// File: rtl/mc_latch_pkg.sv
package mc_latch_pkg;
  typedef struct packed {
    logic latchAddr;   // capture address/direction of a new transaction
    logic captureErr;  // copy latched address/direction into status
  } mclStrobes_t;
endpackage

// File: rtl/mc_latch_dp.sv
module mc_latch_dp
  import mc_latch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] VEC_LO = 32'h0000_0200,
  parameter logic [ADDR_W-1:0] VEC_HI = 32'hFFF0_0200,
  parameter int WIN_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mclStrobes_t       strobes,
  input  logic [ADDR_W-1:0] abAddr,
  input  logic              abRead,
  output logic              ackHit,
  output logic [ADDR_W-1:0] stsAddr,
  output logic              stsWasWrite
);
  localparam int WIN_LG = $clog2(WIN_BYTES);
  localparam int N_VEC = 2;
  localparam logic [N_VEC-1:0][ADDR_W-1:0] BASES = {VEC_HI, VEC_LO};

  logic [ADDR_W-1:0] curAddr;
  logic              curRead;
  logic [N_VEC-1:0]  winHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      curRead <= 1'b0;
    end else if (strobes.latchAddr) begin
      curAddr <= abAddr;
      curRead <= abRead;
    end
  end

  for (genvar g = 0; g < N_VEC; g++) begin : gWin
    assign winHit[g] = (curAddr[ADDR_W-1:WIN_LG] == BASES[g][ADDR_W-1:WIN_LG]);
  end

  assign ackHit = curRead && (|winHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsAddr     <= '0;
      stsWasWrite <= 1'b0;
    end else if (strobes.captureErr) begin
      stsAddr     <= curAddr;
      stsWasWrite <= !curRead;
    end
  end
endmodule

// File: rtl/mc_latch_ctrl.sv
module mc_latch_ctrl
  import mc_latch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        abStart,
  input  logic        xferDone,
  input  logic        xferErr,
  input  logic        ackHit,
  input  logic        mcEnable,
  input  logic        stsClr,
  output mclStrobes_t strobes,
  output logic        mcpN,
  output logic        stsValid,
  output logic        stsOverflow
);
  logic pending;
  logic errEv;
  logic ackEv;

  assign errEv = xferDone && xferErr;
  assign ackEv = xferDone && !xferErr && ackHit;

  always_comb begin
    strobes = '0;
    strobes.latchAddr  = abStart;
    strobes.captureErr = errEv && (!stsValid || stsClr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending     <= 1'b0;
      stsValid    <= 1'b0;
      stsOverflow <= 1'b0;
    end else begin
      if (errEv)      pending <= 1'b1;
      else if (ackEv) pending <= 1'b0;

      if (errEv)       stsValid <= 1'b1;
      else if (stsClr) stsValid <= 1'b0;

      if (errEv && pending) stsOverflow <= 1'b1;
      else if (stsClr)      stsOverflow <= 1'b0;
    end
  end

  assign mcpN = !(pending && mcEnable);
endmodule

// File: rtl/mc_latch.sv
module mc_latch
  import mc_latch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] VEC_LO = 32'h0000_0200,
  parameter logic [ADDR_W-1:0] VEC_HI = 32'hFFF0_0200,
  parameter int WIN_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              abStart,
  input  logic [ADDR_W-1:0] abAddr,
  input  logic              abRead,
  input  logic              xferDone,
  input  logic              xferErr,
  input  logic              mcEnable,
  input  logic              stsClr,
  output logic              mcpN,
  output logic              stsValid,
  output logic              stsOverflow,
  output logic [ADDR_W-1:0] stsAddr,
  output logic              stsWasWrite
);
  mclStrobes_t strobes;
  logic        ackHit;

  mc_latch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .abStart(abStart), .xferDone(xferDone),
    .xferErr(xferErr), .ackHit(ackHit), .mcEnable(mcEnable), .stsClr(stsClr),
    .strobes(strobes), .mcpN(mcpN), .stsValid(stsValid), .stsOverflow(stsOverflow)
  );

  mc_latch_dp #(
    .ADDR_W(ADDR_W), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI), .WIN_BYTES(WIN_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .abAddr(abAddr), .abRead(abRead),
    .ackHit(ackHit), .stsAddr(stsAddr), .stsWasWrite(stsWasWrite)
  );
endmodule

// File: rtl/mc_latch_chk.sv
module mc_latch_chk (
  input logic clk,
  input logic rstN,
  input logic xferDone,
  input logic xferErr,
  input logic ackHit,
  input logic mcEnable,
  input logic stsClr,
  input logic mcpN,
  input logic stsOverflow
);
  AST_ERR_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && xferErr && mcEnable) |=> (!mcpN || !mcEnable)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!mcpN && !xferDone && mcEnable) |=> (!mcpN || !mcEnable)); // R2
  AST_NO_FALSE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (!mcpN && xferDone && !ackHit && mcEnable) |=> (!mcpN || !mcEnable)); // R6
  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!mcpN && xferDone && xferErr) |=> stsOverflow); // R7
  AST_CLR_KEEPS_MC: assert property (@(posedge clk) disable iff (!rstN)
    (stsClr && !xferDone && !mcpN && mcEnable) |=> (!mcpN || !mcEnable)); // R8
  AST_MASK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !mcEnable |-> mcpN); // R10
endmodule

bind mc_latch mc_latch_chk u_chk (
  .clk(clk), .rstN(rstN), .xferDone(xferDone), .xferErr(xferErr),
  .ackHit(ackHit), .mcEnable(mcEnable), .stsClr(stsClr), .mcpN(mcpN),
  .stsOverflow(stsOverflow)
);

// File: tb/mc_latch_tb.sv
`timescale 1ns/1ps
module mc_latch_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        abStart = 1'b0;
  logic [31:0] abAddr = '0;
  logic        abRead = 1'b0;
  logic        xferDone = 1'b0;
  logic        xferErr = 1'b0;
  logic        mcEnable = 1'b1;
  logic        stsClr = 1'b0;
  logic        mcpN, stsValid, stsOverflow, stsWasWrite;
  logic [31:0] stsAddr;

  int nChecks = 0;
  int nFails = 0;
  logic midMcp;

  always #4 clk = ~clk;

  mc_latch u_dut (
    .clk(clk), .rstN(rstN), .abStart(abStart), .abAddr(abAddr), .abRead(abRead),
    .xferDone(xferDone), .xferErr(xferErr), .mcEnable(mcEnable), .stsClr(stsClr),
    .mcpN(mcpN), .stsValid(stsValid), .stsOverflow(stsOverflow),
    .stsAddr(stsAddr), .stsWasWrite(stsWasWrite)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One transaction; midMcp = mcpN seen before the completion edge.
  task automatic xfer(input logic [31:0] a, input logic rd, input logic err, input logic clr);
    @(negedge clk); abStart = 1'b1; abAddr = a; abRead = rd;
    @(negedge clk); abStart = 1'b0; abAddr = '0;
    @(negedge clk); midMcp = mcpN; xferDone = 1'b1; xferErr = err; stsClr = clr;
    @(negedge clk); xferDone = 1'b0; xferErr = 1'b0; stsClr = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk); stsClr = 1'b1;
    @(negedge clk); stsClr = 1'b0;
  endtask

  task automatic tReset();
    check(mcpN == 1'b1, "R11 mcpN", 32'(mcpN), 1);
    check(stsValid == 1'b0, "R11 stsValid", 32'(stsValid), 0);
    check(stsOverflow == 1'b0, "R11 stsOverflow", 32'(stsOverflow), 0);
  endtask

  task automatic tRaiseAndHold();
    xfer(32'h1234_5670, 1'b0, 1'b1, 1'b0);
    check(mcpN == 1'b0, "R1 mcpN low", 32'(mcpN), 0);
    check(stsValid == 1'b1, "R1 stsValid", 32'(stsValid), 1);
    check(stsAddr == 32'h1234_5670, "R1 stsAddr", stsAddr, 32'h1234_5670);
    check(stsWasWrite == 1'b1, "R1 stsWasWrite", 32'(stsWasWrite), 1);
    repeat (5) @(negedge clk);
    check(mcpN == 1'b0, "R2 idle hold", 32'(mcpN), 0);
    xfer(32'h0000_1000, 1'b1, 1'b0, 1'b0);
    check(mcpN == 1'b0, "R2 unrelated read", 32'(mcpN), 0);
  endtask

  task automatic tNoRelease();
    xfer(32'h0000_0200, 1'b0, 1'b0, 1'b0);
    check(mcpN == 1'b0, "R6 write low window", 32'(mcpN), 0);
    xfer(32'hFFF0_0204, 1'b0, 1'b0, 1'b0);
    check(mcpN == 1'b0, "R6 write high window", 32'(mcpN), 0);
    xfer(32'h0000_01FF, 1'b1, 1'b0, 1'b0);
    check(mcpN == 1'b0, "R6 read 0x1FF", 32'(mcpN), 0);
    xfer(32'h0000_0208, 1'b1, 1'b0, 1'b0);
    check(mcpN == 1'b0, "R6 read 0x208", 32'(mcpN), 0);
    xfer(32'hFFF0_0208, 1'b1, 1'b0, 1'b0);
    check(mcpN == 1'b0, "R6 read 0xFFF00208", 32'(mcpN), 0);
  endtask

  task automatic tLowAck();
    xfer(32'h0000_0204, 1'b1, 1'b0, 1'b0);
    check(midMcp == 1'b0, "R5 held before completion", 32'(midMcp), 0);
    check(mcpN == 1'b1, "R3 low window release", 32'(mcpN), 1);
  endtask

  task automatic tHighAck();
    xfer(32'h0000_4000, 1'b1, 1'b1, 1'b0);
    check(mcpN == 1'b0, "R1 second raise", 32'(mcpN), 0);
    check(stsAddr == 32'h1234_5670, "R8 sticky addr", stsAddr, 32'h1234_5670);
    check(stsOverflow == 1'b0, "R7 no overflow when idle", 32'(stsOverflow), 0);
    xfer(32'hFFF0_0207, 1'b1, 1'b0, 1'b0);
    check(midMcp == 1'b0, "R5 high held before completion", 32'(midMcp), 0);
    check(mcpN == 1'b1, "R4 high window release", 32'(mcpN), 1);
  endtask

  task automatic tOverflowClr();
    pulseClr();
    check(stsValid == 1'b0, "R8 clear valid", 32'(stsValid), 0);
    xfer(32'h0000_A000, 1'b1, 1'b1, 1'b0);
    check(stsWasWrite == 1'b0, "R1 read error direction", 32'(stsWasWrite), 0);
    xfer(32'h0000_B000, 1'b0, 1'b1, 1'b0);
    check(stsOverflow == 1'b1, "R7 overflow", 32'(stsOverflow), 1);
    check(mcpN == 1'b0, "R7 still low", 32'(mcpN), 0);
    check(stsAddr == 32'h0000_A000, "R8 first addr kept", stsAddr, 32'h0000_A000);
    pulseClr();
    check(stsOverflow == 1'b0 && stsValid == 1'b0, "R8 clear flags", {stsOverflow, stsValid}, 0);
    check(mcpN == 1'b0, "R8 clear keeps mc", 32'(mcpN), 0);
    xfer(32'h0000_C000, 1'b0, 1'b1, 1'b1);
    check(stsValid == 1'b1, "R8 err beats clear", 32'(stsValid), 1);
    check(stsAddr == 32'h0000_C000, "R8 err addr on clear", stsAddr, 32'h0000_C000);
  endtask

  task automatic tErrInWindow();
    pulseClr();
    xfer(32'h0000_0200, 1'b1, 1'b1, 1'b0);
    check(mcpN == 1'b0, "R9 window read error stays", 32'(mcpN), 0);
    check(stsOverflow == 1'b1, "R9 overflow", 32'(stsOverflow), 1);
    xfer(32'h0000_0200, 1'b1, 1'b0, 1'b0);
    check(mcpN == 1'b1, "R3 release 0x200", 32'(mcpN), 1);
  endtask

  task automatic tMask();
    pulseClr();
    @(negedge clk); mcEnable = 1'b0;
    xfer(32'h0000_D000, 1'b0, 1'b1, 1'b0);
    check(mcpN == 1'b1, "R10 masked high", 32'(mcpN), 1);
    check(stsValid == 1'b1, "R10 captured while masked", 32'(stsValid), 1);
    @(negedge clk); mcEnable = 1'b1;
    #1;
    check(mcpN == 1'b0, "R10 unmask asserts", 32'(mcpN), 0);
    xfer(32'hFFF0_0200, 1'b1, 1'b0, 1'b0);
    check(mcpN == 1'b1, "R4 release after unmask", 32'(mcpN), 1);
  endtask

  initial begin
    #(8 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRaiseAndHold();
    tNoRelease();
    tLowAck();
    tHighAck();
    tOverflowClr();
    tErrInWindow();
    tMask();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule